// File: doc/BRIEF.md
# Two-Level Interrupt Controller for an 8-bit Core

This block collects the interrupt events of a small 8-bit microcontroller and decides when the core must jump to its interrupt handler. Seven sources feed it. Three are core-level sources: an external pin, a port-change detector and the first timer's overflow. Four are peripheral-level sources: the second timer's overflow, a comparator, an A/D conversion and a data-EEPROM write. Each source has a sticky flag. The core sources keep their flags and enables in a control register. The peripheral sources keep their flags in a peripheral flag register and their enables in a peripheral enable register.

A request reaches the core only when the global enable is set and an enabled flag is pending. A peripheral flag also needs the peripheral-group enable. The core signals each instruction boundary. At a boundary where a request is pending, the block pulses a vector request and a push request, and the vector address is 0x0004. Taking the interrupt clears the global enable, and a return-from-interrupt strobe sets it again. The external pin and the port lines pass through two-flop synchronizers before any edge or change is detected.

Top module: `irq_controller`

## Requirements
- R1: After reset, the control register (address 0), the peripheral flag register (address 1) and the peripheral enable register (address 2) all read 0x00, and vec_req and push_req are low.
- R2: A write to address 0 loads the whole control register, and a read returns it. Bit 0 is the pin flag, bit 1 the port-change flag, bit 2 the timer0 flag, bits 3/4/5 their enables, bit 6 the peripheral-group enable and bit 7 the global enable. Addresses 1 and 2 use bits 3:0 (bit 0 timer1, bit 1 comparator, bit 2 A/D, bit 3 EEPROM), and their bits 7:4 read as 0.
- R3: An event sets its flag one clock after its pulse, whatever the state of its own enable, the group enable or the global enable. If the event arrives in the same cycle as a write to its register, the flag ends up set.
- R4: A flag is cleared only by a register write. It stays set across idle cycles and across a taken interrupt.
- R5: Suppose the global enable is set, an enabled core flag is pending and insn_boundary is high. Then on the next clock vec_req and push_req go high for exactly one cycle, vec_addr reads 0x0004 and the global enable reads 0.
- R6: A pending, enabled peripheral flag causes no vector while bit 6 is clear. It causes a vector once bit 6 is set.
- R7: No vector is raised while the global enable is clear, and none is raised in a cycle without insn_boundary.
- R8: A write that clears the global enable one cycle before a boundary suppresses the interrupt, and the flag stays set. Setting the global enable again raises the vector on the next boundary.
- R9: A retfie pulse sets the global enable. A flag still pending at that point vectors again one cycle later. With the flag cleared, no vector follows.
- R10: The pin flag is set on a rising edge of ext_pin when ext_rise is 1 and on a falling edge when it is 0. With insn_boundary high every clock, vec_req rises on the 4th clock edge after the pin change. With insn_boundary high every other clock, it rises on the 4th or 5th edge, depending on the phase.
- R11: The port-change flag is set while the synchronized port differs from a copy held in the block. A port_rd pulse reloads that copy from the synchronized port. After the reload, a write can clear the flag and it stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 peripheral flags, 2 peripheral enables) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_rise | input | 1 | 1 selects rising edge, 0 selects falling edge |
| port_in | input | PORT_W | Port lines watched for change (asynchronous) |
| port_rd | input | 1 | Port read strobe; reloads the comparison copy |
| tmr0_ovf | input | 1 | Timer0 overflow pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| cmp_evt | input | 1 | Comparator change pulse |
| adc_done | input | 1 | A/D conversion complete pulse |
| ee_done | input | 1 | EEPROM write complete pulse |
| insn_boundary | input | 1 | Instruction boundary strobe from the core |
| retfie | input | 1 | Return-from-interrupt strobe |
| vec_req | output | 1 | One-cycle request to load the vector address |
| push_req | output | 1 | One-cycle request to push the return address |
| vec_addr | output | PC_W | Interrupt vector address (0x0004) |

## Verification
The vectoring decision is tested against several patterns. Masked events on every source show that latching does not depend on the enables. An enabled peripheral flag with the group bit clear and then set isolates the second enable level. A global-enable clear written just before the boundary separates suppression from flag loss. Pin edges of both polarities, with boundaries on every clock and on every second clock in both phases, pin down the exact latency window. Port changes before and after a port_rd reload show that the comparison copy, and not the raw port, decides when the flag can be cleared.

// File: rtl/irq_pkg.sv
// Package: shared register addresses and bit positions for the interrupt controller.
// Assumes: 8-bit register port, two-bit address.
package irq_pkg;
    localparam int DW       = 8;
    localparam int CORE_N   = 3;
    localparam int PERI_N   = 4;
    localparam int GIE_BIT  = 7;
    localparam int PGE_BIT  = 6;
    localparam int CEN_LSB  = CORE_N;
    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_PFLAG = 2'd1;
    localparam logic [1:0] A_PEN   = 2'd2;
endpackage

// File: rtl/irq_sync2.sv
// Module: two-flop synchronizer for a bus of asynchronous inputs.
// Assumes: each bit is independent; no bus coherency is implied.
module irq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage resampling into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irq_flag_reg.sv
// Module: a group of sticky interrupt flags.
// A write loads the flags, and a same-cycle event still sets its bit.
// Assumes: events are single-cycle synchronous pulses or levels.
module irq_flag_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] flags
);
    // Flag update: the written value OR any incoming event.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (wr ? wdata : flags) | evt;
    end

    assert_flag_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/irq_event_sync.sv
// Module: turns the asynchronous pin and port lines into flag events.
// The pin gives an event on the selected edge. The port gives an event
// while its synchronized value differs from a copy reloaded on port reads.
// Assumes: ext_rise changes only while the pin is stable.
module irq_event_sync #(
    parameter int PORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              ext_rise,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    output logic              ext_evt,
    output logic              port_evt
);
    localparam int SW = PORT_W + 1;

    logic [SW-1:0]     sync_q;
    logic              ext_s;
    logic              ext_prev;
    logic [PORT_W-1:0] port_s;
    logic [PORT_W-1:0] port_copy;

    irq_sync2 #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_pin, port_in}),
        .q     (sync_q)
    );

    assign ext_s  = sync_q[PORT_W];
    assign port_s = sync_q[PORT_W-1:0];

    // Edge history for the pin and the port comparison copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev  <= 1'b0;
            port_copy <= '0;
        end else begin
            ext_prev <= ext_s;
            if (port_rd) port_copy <= port_s;
        end
    end

    // Event decode: the selected pin edge, and any port mismatch.
    always_comb begin
        ext_evt  = ext_rise ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
        port_evt = |(port_s ^ port_copy);
    end

    assert_port_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> (port_copy == $past(port_s)));
endmodule

// File: rtl/irq_controller.sv
// Module: top of the two-level interrupt controller.
// Holds the flag and enable registers and the global and group enables.
// Raises a one-cycle vector and push request at an instruction boundary.
// Assumes: the core samples vec_req, pushes the return address and
// loads vec_addr into the program counter in the same cycle.
module irq_controller
    import irq_pkg::*;
#(
    parameter int              PORT_W   = 6,
    parameter int              PC_W     = 13,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              ext_pin,
    input  logic              ext_rise,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              cmp_evt,
    input  logic              adc_done,
    input  logic              ee_done,
    input  logic              insn_boundary,
    input  logic              retfie,
    output logic              vec_req,
    output logic              push_req,
    output logic [PC_W-1:0]   vec_addr
);
    localparam int PAD = DW - PERI_N;

    logic              ext_evt, port_evt;
    logic              wr_ctrl, wr_pflag, wr_pen;
    logic [CORE_N-1:0] core_flags, core_en;
    logic [PERI_N-1:0] peri_flags, peri_en;
    logic              pge_q, gie_q, vec_q;
    logic              any_req, take;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_pflag = reg_wr && (reg_addr == A_PFLAG);
    assign wr_pen   = reg_wr && (reg_addr == A_PEN);

    irq_event_sync #(.PORT_W(PORT_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_pin),
        .ext_rise (ext_rise),
        .port_in  (port_in),
        .port_rd  (port_rd),
        .ext_evt  (ext_evt),
        .port_evt (port_evt)
    );

    irq_flag_reg #(.W(CORE_N)) u_core_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ctrl),
        .wdata (reg_wdata[CORE_N-1:0]),
        .evt   ({tmr0_ovf, port_evt, ext_evt}),
        .flags (core_flags)
    );

    irq_flag_reg #(.W(PERI_N)) u_peri_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_pflag),
        .wdata (reg_wdata[PERI_N-1:0]),
        .evt   ({ee_done, adc_done, cmp_evt, tmr1_ovf}),
        .flags (peri_flags)
    );

    // Request decision: an enabled flag from either level, gated at a boundary.
    always_comb begin
        any_req = |(core_flags & core_en) | (pge_q & |(peri_flags & peri_en));
        take    = insn_boundary & gie_q & any_req;
    end

    // Enable registers; the global enable gives priority to take, then return, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_en <= '0;
            peri_en <= '0;
            pge_q   <= 1'b0;
            gie_q   <= 1'b0;
            vec_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                core_en <= reg_wdata[CEN_LSB +: CORE_N];
                pge_q   <= reg_wdata[PGE_BIT];
            end
            if (wr_pen) peri_en <= reg_wdata[PERI_N-1:0];
            if (take)         gie_q <= 1'b0;
            else if (retfie)  gie_q <= 1'b1;
            else if (wr_ctrl) gie_q <= reg_wdata[GIE_BIT];
            vec_q <= take;
        end
    end

    // Read mux over the three registers.
    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {gie_q, pge_q, core_en, core_flags};
            A_PFLAG: reg_rdata = {{PAD{1'b0}}, peri_flags};
            A_PEN:   reg_rdata = {{PAD{1'b0}}, peri_en};
            default: reg_rdata = '0;
        endcase
    end

    assign vec_req  = vec_q;
    assign push_req = vec_q;
    assign vec_addr = VEC_ADDR;

    assert_vec_clears_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q |-> !gie_q);
    assert_vec_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q |=> !vec_q);
    assert_vec_needs_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_q) |-> ($past(gie_q) && $past(insn_boundary)));
    assert_peri_needs_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_q) |-> ($past(|(core_flags & core_en)) || $past(pge_q)));
    assert_retfie_sets_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (retfie && !take) |=> gie_q);
endmodule

// File: tb/irq_controller_test.sv
// Bench: directed scenarios, one task each, each checking its own results.
module irq_controller_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        ext_pin = 1'b0, ext_rise = 1'b1;
    logic [5:0]  port_in = 6'd0;
    logic        port_rd = 1'b0;
    logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, cmp_evt = 1'b0;
    logic        adc_done = 1'b0, ee_done = 1'b0;
    logic        insn_boundary = 1'b1, retfie = 1'b0;
    logic        vec_req, push_req;
    logic [12:0] vec_addr;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    irq_controller uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .ext_rise(ext_rise), .port_in(port_in), .port_rd(port_rd),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .cmp_evt(cmp_evt),
        .adc_done(adc_done), .ee_done(ee_done), .insn_boundary(insn_boundary),
        .retfie(retfie), .vec_req(vec_req), .push_req(push_req), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // Counts negedges until vec_req is seen, up to lim.
    task automatic wait_vec(input int lim, output int n);
        n = 0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            n++;
            if (vec_req) return;
        end
        n = -1;
    endtask

    task automatic no_vec(input string req, input int cycles);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (vec_req) seen = 1;
        end
        chk(req, seen, 0);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 pflag", 2'd1, 8'h00);
        rd_chk("R1 pen", 2'd2, 8'h00);
        chk("R1 vec_req", vec_req, 0);
        chk("R1 push_req", push_req, 0);
    endtask

    task automatic t_regs;
        wr(2'd2, 8'hFF);
        rd_chk("R2 pen upper bits zero", 2'd2, 8'h0F);
        wr(2'd0, 8'h78);
        rd_chk("R2 ctrl readback", 2'd0, 8'h78);
        wr(2'd1, 8'h05);
        rd_chk("R2 pflag readback", 2'd1, 8'h05);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_masked_latch;
        @(negedge clk);
        tmr0_ovf = 1; tmr1_ovf = 1; cmp_evt = 1; adc_done = 1; ee_done = 1;
        @(negedge clk);
        tmr0_ovf = 0; tmr1_ovf = 0; cmp_evt = 0; adc_done = 0; ee_done = 0;
        rd_chk("R3 core flag masked", 2'd0, 8'h04);
        rd_chk("R3 peri flags masked", 2'd1, 8'h0F);
        chk("R3 no vector when masked", vec_req, 0);
        repeat (5) @(negedge clk);
        rd_chk("R4 flags sticky", 2'd1, 8'h0F);
        // A write of zero in the same cycle as an event: the event wins.
        reg_wr = 1; reg_addr = 2'd1; reg_wdata = 8'h00; tmr1_ovf = 1;
        @(negedge clk);
        reg_wr = 0; tmr1_ovf = 0;
        rd_chk("R3 event beats write", 2'd1, 8'h01);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_core_vector_and_return;
        wr(2'd0, 8'hA0);
        @(negedge clk) tmr0_ovf = 1;
        @(negedge clk) tmr0_ovf = 0;
        chk("R5 no vector yet", vec_req, 0);
        rd_chk("R5 flag set before vector", 2'd0, 8'hA4);
        @(negedge clk);
        chk("R5 vec_req", vec_req, 1);
        chk("R5 push_req", push_req, 1);
        chk("R5 vec_addr", vec_addr, 13'h0004);
        rd_chk("R5 gie cleared, R4 flag kept", 2'd0, 8'h24);
        @(negedge clk);
        chk("R5 single pulse", vec_req, 0);
        retfie = 1;
        @(negedge clk) retfie = 0;
        chk("R9 no vector in retfie cycle", vec_req, 0);
        @(negedge clk);
        chk("R9 repeat vector on pending flag", vec_req, 1);
        wr(2'd0, 8'h20);
        @(negedge clk) retfie = 1;
        @(negedge clk) retfie = 0;
        no_vec("R9 no vector after flag cleared", 4);
        rd_chk("R9 gie set by retfie", 2'd0, 8'hA0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_peripheral_group;
        int n;
        wr(2'd2, 8'h01);
        @(negedge clk) tmr1_ovf = 1;
        @(negedge clk) tmr1_ovf = 0;
        wr(2'd0, 8'h80);
        no_vec("R6 no vector without group enable", 4);
        wr(2'd0, 8'hC0);
        wait_vec(4, n);
        chk("R6 vector with group enable", n, 1);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_boundary_and_cancel;
        int n;
        insn_boundary = 0;
        wr(2'd0, 8'hA0);
        @(negedge clk) tmr0_ovf = 1;
        @(negedge clk) tmr0_ovf = 0;
        repeat (2) @(negedge clk);
        chk("R7 no vector without boundary", vec_req, 0);
        // Clear the global enable (keeping flag and enable), then open the boundary.
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h24;
        @(negedge clk);
        reg_wr = 0; insn_boundary = 1;
        no_vec("R8 cancelled interrupt", 4);
        rd_chk("R8 flag still pending", 2'd0, 8'h24);
        wr(2'd0, 8'hA4);
        wait_vec(3, n);
        chk("R8 pending taken after gie set", n, 1);
        wr(2'd0, 8'h00);
    endtask

    task automatic pin_latency(input logic lvl, input int ph, output int n);
        @(negedge clk);
        ext_pin = lvl;
        n = -1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (vec_req) begin n = k; break; end
            if (ph >= 0) insn_boundary = ((k + ph) % 2) == 1;
        end
        insn_boundary = 1;
    endtask

    task automatic t_pin;
        int n;
        wr(2'd0, 8'h88);
        ext_rise = 1;
        pin_latency(1'b1, -1, n);
        chk("R10 rising latency every-clock boundary", n, 4);
        wr(2'd0, 8'h88);
        pin_latency(1'b0, -1, n);
        chk("R10 falling edge ignored in rise mode", n, -1);
        rd_chk("R10 no flag on wrong edge", 2'd0, 8'h88);
        ext_rise = 0;
        pin_latency(1'b1, -1, n);
        chk("R10 rising edge ignored in fall mode", n, -1);
        insn_boundary = 0;
        pin_latency(1'b0, 0, n);
        chk("R10 falling latency two-clock phase 0", n, 4);
        wr(2'd0, 8'h88);
        ext_rise = 1;
        insn_boundary = 1;
        pin_latency(1'b1, 1, n);
        chk("R10 rising latency two-clock phase 1", n, 5);
        wr(2'd0, 8'h00);
        ext_pin = 0;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_port;
        int n;
        wr(2'd0, 8'h90);
        @(negedge clk) port_in = 6'b000100;
        wait_vec(8, n);
        chk("R11 port change vectors", n, 4);
        wr(2'd0, 8'h10);
        rd_chk("R11 flag re-set while copy stale", 2'd0, 8'h12);
        @(negedge clk) port_rd = 1;
        @(negedge clk) port_rd = 0;
        wr(2'd0, 8'h00);
        repeat (3) @(negedge clk);
        rd_chk("R11 flag stays clear after reload", 2'd0, 8'h00);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_masked_latch;
        t_core_vector_and_return;
        t_peripheral_group;
        t_boundary_and_cancel;
        t_pin;
        t_port;
        summary;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
    end
endmodule